// File: doc/BRIEF.md
# Banked Level Interrupt Controller with Shortcut Status

This block collects 72 level-sensitive interrupt sources into three groups and presents them to a processor through one IRQ line and one FIQ line. The basic group has 8 sources. Each of the two high groups has 32 sources. Each group has a mask that is set through a write-one-to-enable register and cleared through a write-one-to-disable register. Each group also has a status register that shows which of its sources are both asserted and enabled.

The basic status word also summarises the two high groups, so that a handler can find most interrupts with one read. A few selected high-group sources appear directly as their own bits in the basic status word. Those sources are left out of their group's summary bit. The summary bits and the direct bits are not masked through the basic group. Only the mask of the owning group gates a direct bit.

A fast-interrupt selector routes one source, taken from the raw source levels, to the FIQ output. It picks the source by a linear index in which the first high group comes first. Software reaches all registers through a simple 32-bit read/write port with byte offsets. Reads are combinational.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every source is masked, the FIQ control register holds zero, all status reads return zero even with every source asserted, and both irq_o and fiq_o are low.
- R2: A write to an enable register (byte offset 0x18 for the basic group, 0x10 for high group 1, 0x14 for high group 2) unmasks each source whose data bit is 1. Data bits that are 0 leave the mask unchanged. The mask change shows in the status read in the cycle after the write.
- R3: A write to a disable register (byte offset 0x24 basic, 0x1C group 1, 0x20 group 2) masks each source whose data bit is 1. Data bits that are 0 leave the mask unchanged.
- R4: Status of group 1 (offset 0x04) and group 2 (offset 0x08) equals source AND mask. Bits 7:0 of the basic status (offset 0x00) equal basic source AND mask. Basic status bits 31:21 read as zero.
- R5: Basic status bit 8 is 1 exactly when an enabled, asserted group-1 source that is not a direct source is present. Bit 9 is 1 under the same rule for group 2.
- R6: Group-1 sources 7, 9, 10, 18 and 19 appear, in that order, on basic status bits 10 to 14. Group-2 sources 21, 22, 23, 24, 25 and 30 appear, in that order, on bits 15 to 20. Each such bit needs the source to be asserted and enabled in its own group. The source also keeps its own bit in its group status.
- R7: Writes to bits 8 and above of the basic enable and disable registers have no effect. Summary bits and direct bits cannot be masked there.
- R8: irq_o is 1 exactly when any bit of the basic status word is 1.
- R9: The FIQ control register (offset 0x0C) stores bits 7:0 of a write and reads back with bits 31:8 as zero. Bits 6:0 give the source index and bit 7 enables the output. Without bit 7, or with an index of 72 or more, fiq_o is low.
- R10: Index 0-31 selects group-1 source n, 32-63 selects group-2 source n-32, and 64-71 selects basic source n-64. fiq_o follows the raw level of that source whatever its mask, and an enabled source also raises irq_o at the same time.
- R11: Reads of the enable and disable offsets, of unmapped offsets and of offsets not aligned to a word return zero. Writes to those, and to the status offsets, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_basic_i | input | 8 | Basic group source levels |
| src_hi1_i | input | 32 | High group 1 source levels |
| src_hi2_i | input | 32 | High group 2 source levels |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Combined interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Assertions check on every cycle that a mask write sets or clears exactly the bits it names and that idle cycles leave masks alone. They also check that a direct bit or summary bit never shows without an enabled source behind it in its group. Further checks cover the FIQ control register capturing the written byte, and both outputs never rising without some asserted source. The exact bit positions of the direct mapping, the exclusion of direct sources from the summaries and the linear FIQ index order cannot be seen from any single relation. The same holds for the writes that must be ignored. Only the bench's directed scenarios can show these, by comparing register reads and output levels with independently computed values.

// File: rtl/birq_pkg.sv
package birq_pkg;
  localparam int BASIC_N   = 8;
  localparam int HI_N      = 32;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 6;
  localparam int N_DIR1    = 5;
  localparam int N_DIR2    = 6;
  localparam int SUM1_POS  = 8;
  localparam int SUM2_POS  = 9;
  localparam int DIR1_BASE = 10;
  localparam int DIR2_BASE = DIR1_BASE + N_DIR1;
  localparam int STAT_USED = DIR2_BASE + N_DIR2;
  localparam int FIQ_W     = 8;
  localparam int FIQ_IDX_W = 7;
  localparam int FIQ_EN_POS = 7;
  localparam int NSRC      = 2 * HI_N + BASIC_N;

  localparam logic [ADDR_W-1:0] OFS_STAT0 = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT1 = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT2 = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_FIQ   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_EN1   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_EN2   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_EN0   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_DIS1  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_DIS2  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_DIS0  = 6'h24;

  // direct-bit source lists; order fixes the status bit position
  function automatic int dir1_src(int k);
    case (k)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      default: return 19;
    endcase
  endfunction

  function automatic int dir2_src(int k);
    case (k)
      0: return 21;
      1: return 22;
      2: return 23;
      3: return 24;
      4: return 25;
      default: return 30;
    endcase
  endfunction

  function automatic logic [HI_N-1:0] dir1_mask();
    logic [HI_N-1:0] m;
    m = '0;
    for (int k = 0; k < N_DIR1; k++) m[dir1_src(k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [HI_N-1:0] dir2_mask();
    logic [HI_N-1:0] m;
    m = '0;
    for (int k = 0; k < N_DIR2; k++) m[dir2_src(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/birq_group.sv
module birq_group #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_wr_i,
  input  logic         dis_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '0;
    else if (en_wr_i)  mask_q <= mask_q | wdata_i;
    else if (dis_wr_i) mask_q <= mask_q & ~wdata_i;
  end

  assign pend_o = src_i & mask_q;

  assert_enable_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  assert_disable_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_wr_i && !en_wr_i) |=> ((mask_q & $past(wdata_i)) == '0));
  assert_idle_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_wr_i && !dis_wr_i) |=> $stable(mask_q));
endmodule

// File: rtl/birq_basic_status.sv
module birq_basic_status
  import birq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BASIC_N-1:0] pend0_i,
  input  logic [HI_N-1:0]    pend1_i,
  input  logic [HI_N-1:0]    pend2_i,
  output logic [DATA_W-1:0]  stat_o
);
  localparam logic [HI_N-1:0] M1 = dir1_mask();
  localparam logic [HI_N-1:0] M2 = dir2_mask();

  logic [N_DIR1-1:0] dir1;
  logic [N_DIR2-1:0] dir2;

  for (genvar k = 0; k < N_DIR1; k++) begin : g_dir1
    localparam int S = dir1_src(k);
    assign dir1[k] = pend1_i[S];
  end
  for (genvar k = 0; k < N_DIR2; k++) begin : g_dir2
    localparam int S = dir2_src(k);
    assign dir2[k] = pend2_i[S];
  end

  always_comb begin
    stat_o = '0;
    stat_o[BASIC_N-1:0]                = pend0_i;
    stat_o[SUM1_POS]                   = |(pend1_i & ~M1);
    stat_o[SUM2_POS]                   = |(pend2_i & ~M2);
    stat_o[DIR1_BASE +: N_DIR1]        = dir1;
    stat_o[DIR2_BASE +: N_DIR2]        = dir2;
  end

  assert_sum1_backed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[SUM1_POS] |-> (pend1_i != '0));
  assert_sum2_backed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[SUM2_POS] |-> (pend2_i != '0));
  for (genvar k = 0; k < N_DIR1; k++) begin : g_chk1
    assert_dir1_backed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_o[DIR1_BASE + k] |-> (pend1_i != '0));
  end
  for (genvar k = 0; k < N_DIR2; k++) begin : g_chk2
    assert_dir2_backed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_o[DIR2_BASE + k] |-> (pend2_i != '0));
  end
endmodule

// File: rtl/birq_fiq_sel.sv
module birq_fiq_sel
  import birq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [FIQ_W-1:0] wdata_i,
  input  logic [NSRC-1:0] lin_src_i,
  output logic [FIQ_W-1:0] ctrl_o,
  output logic            fiq_o
);
  logic [FIQ_W-1:0]     ctrl_q;
  logic [FIQ_IDX_W-1:0] idx;
  logic                 in_range;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wdata_i;
  end

  assign idx      = ctrl_q[FIQ_IDX_W-1:0];
  assign in_range = idx < FIQ_IDX_W'(NSRC);
  assign fiq_o    = ctrl_q[FIQ_EN_POS] && in_range && lin_src_i[idx];
  assign ctrl_o   = ctrl_q;

  assert_ctrl_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (ctrl_q == $past(wdata_i)));
  assert_ctrl_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_q));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import birq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BASIC_N-1:0] src_basic_i,
  input  logic [HI_N-1:0]    src_hi1_i,
  input  logic [HI_N-1:0]    src_hi2_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  logic               wr;
  logic [BASIC_N-1:0] pend0;
  logic [HI_N-1:0]    pend1, pend2;
  logic [DATA_W-1:0]  stat0;
  logic [FIQ_W-1:0]   fiq_ctrl;

  assign wr = req_i && we_i;

  birq_group #(.W(BASIC_N)) u_grp0 (
    .clk_i, .rst_ni,
    .en_wr_i (wr && addr_i == OFS_EN0),
    .dis_wr_i(wr && addr_i == OFS_DIS0),
    .wdata_i (wdata_i[BASIC_N-1:0]),
    .src_i   (src_basic_i),
    .pend_o  (pend0)
  );

  birq_group #(.W(HI_N)) u_grp1 (
    .clk_i, .rst_ni,
    .en_wr_i (wr && addr_i == OFS_EN1),
    .dis_wr_i(wr && addr_i == OFS_DIS1),
    .wdata_i (wdata_i[HI_N-1:0]),
    .src_i   (src_hi1_i),
    .pend_o  (pend1)
  );

  birq_group #(.W(HI_N)) u_grp2 (
    .clk_i, .rst_ni,
    .en_wr_i (wr && addr_i == OFS_EN2),
    .dis_wr_i(wr && addr_i == OFS_DIS2),
    .wdata_i (wdata_i[HI_N-1:0]),
    .src_i   (src_hi2_i),
    .pend_o  (pend2)
  );

  birq_basic_status u_stat (
    .clk_i, .rst_ni,
    .pend0_i(pend0),
    .pend1_i(pend1),
    .pend2_i(pend2),
    .stat_o (stat0)
  );

  // linear order: group 1, group 2, basic
  birq_fiq_sel u_fiq (
    .clk_i, .rst_ni,
    .wr_i     (wr && addr_i == OFS_FIQ),
    .wdata_i  (wdata_i[FIQ_W-1:0]),
    .lin_src_i({src_basic_i, src_hi2_i, src_hi1_i}),
    .ctrl_o   (fiq_ctrl),
    .fiq_o    (fiq_o)
  );

  assign irq_o = |stat0;

  always_comb begin
    case (addr_i)
      OFS_STAT0: rdata_o = stat0;
      OFS_STAT1: rdata_o = pend1;
      OFS_STAT2: rdata_o = pend2;
      OFS_FIQ:   rdata_o = DATA_W'(fiq_ctrl);
      default:   rdata_o = '0;
    endcase
  end

  assert_irq_has_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pend0 != '0) || (pend1 != '0) || (pend2 != '0)));
  assert_fiq_has_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> ((src_basic_i != '0) || (src_hi1_i != '0) || (src_hi2_i != '0)));
  assert_fiq_needs_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> fiq_ctrl[FIQ_EN_POS]);
endmodule

// File: tb/banked_irq_ctrl_tb.sv
module banked_irq_ctrl_tb;
  localparam time CLK_P = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  src_basic_i = '0;
  logic [31:0] src_hi1_i = '0;
  logic [31:0] src_hi2_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  banked_irq_ctrl u_dut (
    .clk_i, .rst_ni, .src_basic_i, .src_hi1_i, .src_hi2_i,
    .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o, .fiq_o
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic do_reset();
    src_basic_i = '0; src_hi1_i = '0; src_hi2_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    do_reset();
    src_basic_i = '1; src_hi1_i = '1; src_hi2_i = '1;
    rd("R1 stat0", 6'h00, 32'h0);
    rd("R1 stat1", 6'h04, 32'h0);
    rd("R1 stat2", 6'h08, 32'h0);
    rd("R1 fiqctl", 6'h0C, 32'h0);
    chk("R1 irq", 32'(irq_o), 32'h0);
    chk("R1 fiq", 32'(fiq_o), 32'h0);
  endtask

  task automatic t_mask();
    do_reset();
    src_hi1_i = '1; src_hi2_i = '1;
    wr(6'h10, 32'h0000_00F0);
    rd("R2 en1", 6'h04, 32'h0000_00F0);
    wr(6'h10, 32'h0);
    rd("R2 zero bits", 6'h04, 32'h0000_00F0);
    wr(6'h14, 32'h8000_0001);
    rd("R2 en2", 6'h08, 32'h8000_0001);
    wr(6'h1C, 32'h0000_0030);
    rd("R3 dis1", 6'h04, 32'h0000_00C0);
    wr(6'h1C, 32'h0);
    rd("R3 zero bits", 6'h04, 32'h0000_00C0);
    wr(6'h20, 32'h8000_0000);
    rd("R3 dis2", 6'h08, 32'h0000_0001);
    src_hi1_i = 32'h0000_0040;
    rd("R4 src and mask", 6'h04, 32'h0000_0040);
  endtask

  task automatic t_basic();
    do_reset();
    src_basic_i = 8'hA5;
    wr(6'h18, 32'hFFFF_FFFF);
    rd("R4 basic", 6'h00, 32'h0000_00A5);
    chk("R8 irq basic", 32'(irq_o), 32'h1);
    wr(6'h24, 32'h0000_0021);
    rd("R3 basic dis", 6'h00, 32'h0000_0084);
  endtask

  task automatic t_summary();
    do_reset();
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    src_hi1_i = 32'h0000_0008;
    rd("R5 sum1", 6'h00, 32'h0000_0100);
    src_hi2_i = 32'h0000_0001;
    rd("R5 sum1+sum2", 6'h00, 32'h0000_0300);
    chk("R8 irq summary", 32'(irq_o), 32'h1);
  endtask

  task automatic t_direct();
    do_reset();
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    src_hi1_i = 32'h0000_0080;
    rd("R6 g1 src7", 6'h00, 32'h0000_0400);
    rd("R6 own bit kept", 6'h04, 32'h0000_0080);
    src_hi1_i = 32'h0008_0000;
    rd("R6 g1 src19", 6'h00, 32'h0000_4000);
    src_hi1_i = 32'h0000_0201;
    rd("R6 g1 src9 plus summary", 6'h00, 32'h0000_0900);
    src_hi1_i = '0;
    src_hi2_i = 32'h4000_0000;
    rd("R6 g2 src30", 6'h00, 32'h0010_0000);
    src_hi2_i = 32'h0020_0000;
    rd("R6 g2 src21", 6'h00, 32'h0000_8000);
    src_hi2_i = 32'h0200_0000;
    rd("R6 g2 src25", 6'h00, 32'h0008_0000);
    src_hi2_i = '1; src_hi1_i = '1; src_basic_i = '1;
    wr(6'h18, 32'hFF);
    rd("R4 upper zero", 6'h00, 32'h001F_FFFF);
    wr(6'h20, 32'h4000_0000);
    rd("R6 masked in own group", 6'h00, 32'h000F_FFFF);
  endtask

  task automatic t_basic_mask_ignored();
    do_reset();
    wr(6'h10, 32'hFFFF_FFFF);
    src_hi1_i = 32'h0000_0400;
    wr(6'h24, 32'hFFFF_FF00);
    rd("R7 dis0 no effect on direct", 6'h00, 32'h0000_1000);
    src_hi1_i = 32'h0000_0004;
    wr(6'h24, 32'h0000_0100);
    rd("R7 dis0 no effect on summary", 6'h00, 32'h0000_0100);
    src_hi1_i = '0;
    src_basic_i = 8'hFF;
    wr(6'h18, 32'hFFFF_FF00);
    rd("R7 en0 upper ignored", 6'h00, 32'h0);
    chk("R8 irq low", 32'(irq_o), 32'h0);
  endtask

  task automatic t_fiq();
    do_reset();
    wr(6'h0C, 32'hFFFF_FF85);
    rd("R9 readback", 6'h0C, 32'h0000_0085);
    src_hi1_i = 32'h0000_0020;
    #1;
    chk("R10 fiq raw g1", 32'(fiq_o), 32'h1);
    chk("R10 irq off while masked", 32'(irq_o), 32'h0);
    wr(6'h10, 32'h0000_0020);
    #1;
    chk("R10 both outputs", {30'h0, irq_o, fiq_o}, 32'h3);
    src_hi1_i = '0;
    wr(6'h0C, 32'h0000_00A3);
    src_hi2_i = 32'h0000_0008;
    #1;
    chk("R10 g2 index 35", 32'(fiq_o), 32'h1);
    src_hi2_i = '0;
    wr(6'h0C, 32'h0000_00C2);
    src_basic_i = 8'h04;
    #1;
    chk("R10 basic index 66", 32'(fiq_o), 32'h1);
    src_basic_i = 8'hFB;
    #1;
    chk("R10 other source ignored", 32'(fiq_o), 32'h0);
    src_basic_i = 8'hFF;
    wr(6'h0C, 32'h0000_0042);
    #1;
    chk("R9 enable off", 32'(fiq_o), 32'h0);
    src_hi1_i = '1; src_hi2_i = '1;
    wr(6'h0C, 32'h0000_00E4);
    #1;
    chk("R9 index out of range", 32'(fiq_o), 32'h0);
  endtask

  task automatic t_map();
    do_reset();
    src_hi1_i = '1;
    wr(6'h10, 32'h0000_000F);
    rd("R11 en offset reads zero", 6'h10, 32'h0);
    rd("R11 dis offset reads zero", 6'h1C, 32'h0);
    rd("R11 unmapped", 6'h28, 32'h0);
    rd("R11 unaligned", 6'h05, 32'h0);
    wr(6'h11, 32'hFFFF_FFFF);
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    rd("R11 stray writes ignored", 6'h04, 32'h0000_000F);
    rd("R11 fiq untouched", 6'h0C, 32'h0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mask();
    t_basic();
    t_summary();
    t_direct();
    t_basic_mask_ignored();
    t_fiq();
    t_map();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule